// File: doc/BRIEF.md
# Four-Slice PWM and Capture Timer Bank

The bank holds four identical timer slices behind one byte-wide register port. Each slice has its own clock prescaler and a 16-bit count register. A slice runs in one of three configurations. In the split configuration the count register works as two separate 8-bit PWM counters. In the joined configuration it works as one 16-bit PWM counter. In the capture configuration it is a free-running 16-bit counter that two input pins sample. Each slice owns two pins, and each slice has one interrupt line that goes high when any of its flags is set.

Each slice is controlled by a four-state machine. The states are `ST_IDLE`, `ST_SPLIT`, `ST_JOINED` and `ST_CAPTURE`. The transitions are:
- **start**: `ST_IDLE` moves to the state that the configuration field selects once the run bit is set. The reserved configuration value keeps the slice in `ST_IDLE`.
- **stop**: any running state returns to `ST_IDLE` once the run bit is cleared.

While a slice is in `ST_IDLE`, its counter is held at zero and its working period and duty registers follow the written values. While it runs, software writes go to holding registers. The working copies take these values only when a period completes.

Register map. The address is `{slice, offset}` and the offset is 4 bits:
- 0: control. Bits [1:0] select the configuration: 0 is split, 1 is joined, 2 is capture, 3 is reserved. Bit 2 is run.
- 1: prescale value P.
- 2 and 3: period and duty of the low half.
- 4 and 5: period and duty of the high half.
- 6 and 7: capture 0, low byte then high byte. Read only.
- 8 and 9: capture 1, low byte then high byte. Read only.
- 10: flags. Bit 0 is capture 0, bit 1 is capture 1, bit 2 is overflow. Writing a 1 to a bit clears it.
- 11 and 12: live count, low byte then high byte. Read only.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every register reads 0, every PWM output is low and every interrupt line is low.
- R2: The slice counter advances once every P+1 clocks. A PWM waveform therefore has a period of (P+1)·(period+1) clocks and stays high for (P+1)·duty clocks.
- R3: In the split configuration, pin 2s comes from the low half (offsets 2 and 3) and pin 2s+1 comes from the high half (offsets 4 and 5). Each pin is high for the first duty counts of a period of period+1 counts, and the two halves run independently.
- R4: A duty value of 0 holds the output low for the whole period.
- R5: A duty value greater than the period holds the output high for the whole period.
- R6: In the joined configuration, the 16-bit period is {offset 4, offset 2} and the 16-bit duty is {offset 5, offset 3}. The output is on pin 2s and pin 2s+1 stays low.
- R7: A period or duty value written while the slice runs takes effect only after the current period ends. The pulse in progress keeps its old length.
- R8: In the capture configuration, either edge on pin 2s or pin 2s+1 copies the count into capture 0 or capture 1 and sets flag bit 0 or bit 1. The count copied is the value the count register holds two clocks after the pin changes. Both PWM outputs stay low.
- R9: In the capture configuration, a count wrap from 0xFFFF to 0 sets flag bit 2.
- R10: Writing 1s to the flags register clears those bits. A slice's interrupt line is high whenever any of its flags is set.
- R11: A configuration change written while the slice runs has no effect until the slice passes through `ST_IDLE`. Clearing run stops the outputs and returns the count to 0.
- R12: The slices are independent. Programming one slice does not change another slice's waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | {slice, offset} register address |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| pin_in | input | 8 | Capture inputs, two per slice |
| pwm_out | output | 8 | PWM outputs, two per slice |
| irq | output | 4 | Per-slice interrupt, OR of that slice's flags |

## Verification
The cycle at which each result is due is as follows:
- A register write takes effect on the clock edge that samples it.
- The state machine leaves `ST_IDLE` one edge later.
- A capture holds the count that is read at the falling clock edge when the pin is driven, plus two, because of the synchroniser.

PWM results are measured as numbers of falling-edge samples between output transitions. This makes the high time and period independent of the phase at which the waveform was caught. The buffered-update check samples exactly one and two clocks after a pulse begins. It does this because an unbuffered duty write would end the pulse at the first of those samples.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Configuration field encoding in the control register
    typedef enum logic [1:0] {
        CFG_SPLIT   = 2'd0,
        CFG_JOINED  = 2'd1,
        CFG_CAPTURE = 2'd2,
        CFG_RSVD    = 2'd3
    } cfg_e;

    // Per-slice control states
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SPLIT,
        ST_JOINED,
        ST_CAPTURE
    } state_e;

    localparam int REG_AW = 4;

    localparam logic [REG_AW-1:0] OFS_CTRL    = 4'd0;
    localparam logic [REG_AW-1:0] OFS_PRE     = 4'd1;
    localparam logic [REG_AW-1:0] OFS_PER_LO  = 4'd2;
    localparam logic [REG_AW-1:0] OFS_DUTY_LO = 4'd3;
    localparam logic [REG_AW-1:0] OFS_PER_HI  = 4'd4;
    localparam logic [REG_AW-1:0] OFS_DUTY_HI = 4'd5;
    localparam logic [REG_AW-1:0] OFS_CAP0_LO = 4'd6;
    localparam logic [REG_AW-1:0] OFS_CAP0_HI = 4'd7;
    localparam logic [REG_AW-1:0] OFS_CAP1_LO = 4'd8;
    localparam logic [REG_AW-1:0] OFS_CAP1_HI = 4'd9;
    localparam logic [REG_AW-1:0] OFS_FLAGS   = 4'd10;
    localparam logic [REG_AW-1:0] OFS_CNT_LO  = 4'd11;
    localparam logic [REG_AW-1:0] OFS_CNT_HI  = 4'd12;

    localparam int NUM_FLAGS = 3;
    localparam int FLG_OVF   = 2;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] div,
    output logic         tick
);

    logic [W-1:0] pcnt_q;

    assign tick = en && (pcnt_q == div);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pcnt_q <= '0;
        end else if (pcnt_q == div) begin
            pcnt_q <= '0;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

    // R2: with a nonzero divider, ticks are never back to back
    // R2
    tick_space_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && div != '0) |=> (!tick || div == '0));

endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic edge_o
);

    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-1:0], pin};
        end
    end

    assign edge_o = sh_q[STAGES] ^ sh_q[STAGES-1];

endmodule

// File: rtl/tmr_slice.sv
module tmr_slice
    import tmr_pkg::*;
#(
    parameter int HALF_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [HALF_W-1:0] wdata,
    output logic [HALF_W-1:0] rd_data,
    input  logic [1:0]        pin_in,
    output logic [1:0]        pwm_o,
    output logic              irq_o
);

    // Software-visible holding registers
    logic [HALF_W-1:0] ctrl_q, pre_q, per_lo_q, duty_lo_q, per_hi_q, duty_hi_q;
    // Working copies, count, captures, flags
    logic [CNT_W-1:0]     act_per_q, act_duty_q, cnt_q;
    logic [CNT_W-1:0]     cap_q [2];
    logic [NUM_FLAGS-1:0] flags_q;

    state_e state_q, state_d;
    cfg_e   cfg;
    logic   run, tick, wrap_lo, wrap_hi, wrap_j, in_cap, ovf_evt;
    logic [1:0]           cap_evt;
    logic [NUM_FLAGS-1:0] flg_set, flg_clr;

    assign cfg = cfg_e'(ctrl_q[1:0]);
    assign run = ctrl_q[2];

    // ---------------- register writes ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            pre_q     <= '0;
            per_lo_q  <= '0;
            duty_lo_q <= '0;
            per_hi_q  <= '0;
            duty_hi_q <= '0;
        end else if (wr_en) begin
            unique case (reg_addr)
                OFS_CTRL:    ctrl_q    <= wdata;
                OFS_PRE:     pre_q     <= wdata;
                OFS_PER_LO:  per_lo_q  <= wdata;
                OFS_DUTY_LO: duty_lo_q <= wdata;
                OFS_PER_HI:  per_hi_q  <= wdata;
                OFS_DUTY_HI: duty_hi_q <= wdata;
                default: ;
            endcase
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (run) begin
                    unique case (cfg)
                        CFG_SPLIT:   state_d = ST_SPLIT;
                        CFG_JOINED:  state_d = ST_JOINED;
                        CFG_CAPTURE: state_d = ST_CAPTURE;
                        CFG_RSVD:    state_d = ST_IDLE;
                    endcase
                end
            end
            ST_SPLIT, ST_JOINED, ST_CAPTURE: begin
                if (!run) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // ---------------- prescaler ----------------
    tmr_prescaler #(.W(HALF_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .en   (state_q != ST_IDLE),
        .div  (pre_q),
        .tick (tick)
    );

    assign wrap_lo = tick && (cnt_q[HALF_W-1:0] == act_per_q[HALF_W-1:0]);
    assign wrap_hi = tick && (cnt_q[CNT_W-1:HALF_W] == act_per_q[CNT_W-1:HALF_W]);
    assign wrap_j  = tick && (cnt_q == act_per_q);
    assign in_cap  = (state_q == ST_CAPTURE);
    assign ovf_evt = in_cap && tick && (cnt_q == {CNT_W{1'b1}});

    // ---------------- count and working copies ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            act_per_q  <= '0;
            act_duty_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q      <= '0;
                    act_per_q  <= {per_hi_q, per_lo_q};
                    act_duty_q <= {duty_hi_q, duty_lo_q};
                end
                ST_SPLIT: begin
                    if (wrap_lo) begin
                        cnt_q[HALF_W-1:0]      <= '0;
                        act_per_q[HALF_W-1:0]  <= per_lo_q;
                        act_duty_q[HALF_W-1:0] <= duty_lo_q;
                    end else if (tick) begin
                        cnt_q[HALF_W-1:0] <= cnt_q[HALF_W-1:0] + 1'b1;
                    end
                    if (wrap_hi) begin
                        cnt_q[CNT_W-1:HALF_W]      <= '0;
                        act_per_q[CNT_W-1:HALF_W]  <= per_hi_q;
                        act_duty_q[CNT_W-1:HALF_W] <= duty_hi_q;
                    end else if (tick) begin
                        cnt_q[CNT_W-1:HALF_W] <= cnt_q[CNT_W-1:HALF_W] + 1'b1;
                    end
                end
                ST_JOINED: begin
                    if (wrap_j) begin
                        cnt_q      <= '0;
                        act_per_q  <= {per_hi_q, per_lo_q};
                        act_duty_q <= {duty_hi_q, duty_lo_q};
                    end else if (tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_CAPTURE: begin
                    if (tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        pwm_o = 2'b00;
        unique case (state_q)
            ST_SPLIT: begin
                pwm_o[0] = cnt_q[HALF_W-1:0] < act_duty_q[HALF_W-1:0];
                pwm_o[1] = cnt_q[CNT_W-1:HALF_W] < act_duty_q[CNT_W-1:HALF_W];
            end
            ST_JOINED: begin
                pwm_o[0] = cnt_q < act_duty_q;
            end
            ST_IDLE, ST_CAPTURE: ;
        endcase
    end

    // ---------------- capture inputs ----------------
    for (genvar k = 0; k < 2; k++) begin : g_sync
        tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst    (rst),
            .pin    (pin_in[k]),
            .edge_o (cap_evt[k])
        );
    end

    assign flg_set = {ovf_evt, cap_evt & {2{in_cap}}};
    assign flg_clr = (wr_en && reg_addr == OFS_FLAGS) ? wdata[NUM_FLAGS-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q[0] <= '0;
            cap_q[1] <= '0;
            flags_q  <= '0;
        end else begin
            for (int k = 0; k < 2; k++) begin
                if (in_cap && cap_evt[k]) begin
                    cap_q[k] <= cnt_q;
                end
            end
            flags_q <= (flags_q & ~flg_clr) | flg_set;
        end
    end

    assign irq_o = |flags_q;

    // ---------------- read mux ----------------
    always_comb begin
        rd_data = '0;
        unique case (reg_addr)
            OFS_CTRL:    rd_data = ctrl_q;
            OFS_PRE:     rd_data = pre_q;
            OFS_PER_LO:  rd_data = per_lo_q;
            OFS_DUTY_LO: rd_data = duty_lo_q;
            OFS_PER_HI:  rd_data = per_hi_q;
            OFS_DUTY_HI: rd_data = duty_hi_q;
            OFS_CAP0_LO: rd_data = cap_q[0][HALF_W-1:0];
            OFS_CAP0_HI: rd_data = cap_q[0][CNT_W-1:HALF_W];
            OFS_CAP1_LO: rd_data = cap_q[1][HALF_W-1:0];
            OFS_CAP1_HI: rd_data = cap_q[1][CNT_W-1:HALF_W];
            OFS_FLAGS:   rd_data = {{(HALF_W-NUM_FLAGS){1'b0}}, flags_q};
            OFS_CNT_LO:  rd_data = cnt_q[HALF_W-1:0];
            OFS_CNT_HI:  rd_data = cnt_q[CNT_W-1:HALF_W];
            default:     rd_data = '0;
        endcase
    end

    // ---------------- assertions ----------------
    // R7
    joined_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_JOINED && $past(state_q) == ST_JOINED && !$stable(act_duty_q))
        |-> $past(wrap_j));

    // R4
    duty_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SPLIT && act_duty_q[HALF_W-1:0] == '0) |-> !pwm_o[0]);

    // R3
    split_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SPLIT) |-> (cnt_q[HALF_W-1:0] <= act_per_q[HALF_W-1:0]));

    // R8
    cap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CAPTURE) |-> (pwm_o == 2'b00));

    // R9
    ovf_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_cap && tick && cnt_q == {CNT_W{1'b1}}) |=> flags_q[FLG_OVF]);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |=> (cnt_q == '0));

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int NUM_SLICES  = 4,
    parameter int HALF_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1,
    localparam int ADDR_W     = SEL_W + REG_AW
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [HALF_W-1:0]       wdata,
    output logic [HALF_W-1:0]       rd_data,
    input  logic [2*NUM_SLICES-1:0] pin_in,
    output logic [2*NUM_SLICES-1:0] pwm_out,
    output logic [NUM_SLICES-1:0]   irq
);

    logic [SEL_W-1:0]  sel;
    logic [HALF_W-1:0] slice_rd [NUM_SLICES];

    assign sel = addr[ADDR_W-1:REG_AW];

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        tmr_slice #(
            .HALF_W      (HALF_W),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_slice (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_en && (sel == SEL_W'(s))),
            .reg_addr (addr[REG_AW-1:0]),
            .wdata    (wdata),
            .rd_data  (slice_rd[s]),
            .pin_in   (pin_in[2*s +: 2]),
            .pwm_o    (pwm_out[2*s +: 2]),
            .irq_o    (irq[s])
        );
    end

    assign rd_data = slice_rd[sel];

endmodule

// File: tb/tmr_bank_tb_top.sv
`timescale 1ns/1ps
module tmr_bank_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rd_data;
    logic [7:0] pin_in = '0;
    logic [7:0] pwm_out;
    logic [3:0] irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tmr_bank dut_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rd_data (rd_data),
        .pin_in  (pin_in),
        .pwm_out (pwm_out),
        .irq     (irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reg_wr(input int s, input int r, input int v);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = {s[1:0], r[3:0]};
        wdata = v[7:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input int s, input int r, output logic [7:0] v);
        @(negedge clk);
        addr = {s[1:0], r[3:0]};
        #1 v = rd_data;
    endtask

    task automatic measure(input int pin, output int hi, output int per);
        @(negedge clk);
        while (pwm_out[pin]) @(negedge clk);
        while (!pwm_out[pin]) @(negedge clk);
        hi = 0;
        while (pwm_out[pin]) begin hi++; @(negedge clk); end
        per = hi;
        while (!pwm_out[pin]) begin per++; @(negedge clk); end
    endtask

    task automatic t_reset;
        logic [7:0] v;
        check(pwm_out == 8'h00, "R1 pwm", pwm_out, 0);
        check(irq == 4'h0, "R1 irq", irq, 0);
        reg_rd(0, 0, v);  check(v == 0, "R1 ctrl", v, 0);
        reg_rd(2, 10, v); check(v == 0, "R1 flags", v, 0);
        reg_rd(3, 3, v);  check(v == 0, "R1 duty", v, 0);
    endtask

    task automatic t_split;
        int hi, per;
        reg_wr(0, 2, 3); reg_wr(0, 3, 2);
        reg_wr(0, 4, 4); reg_wr(0, 5, 1);
        reg_wr(0, 0, 8'h04);
        measure(0, hi, per);
        check(hi == 2, "R3 low half high", hi, 2);
        check(per == 4, "R3 low half period", per, 4);
        measure(1, hi, per);
        check(hi == 1, "R3 high half high", hi, 1);
        check(per == 5, "R3 high half period", per, 5);
    endtask

    task automatic t_prescale;
        int hi, per;
        reg_wr(1, 1, 2); reg_wr(1, 2, 2); reg_wr(1, 3, 1);
        reg_wr(1, 0, 8'h04);
        measure(2, hi, per);
        check(hi == 3, "R2 high", hi, 3);
        check(per == 9, "R2 period", per, 9);
        // R12: slice 0 untouched by slice 1 programming
        measure(0, hi, per);
        check(hi == 2, "R12 slice0 high", hi, 2);
        check(per == 4, "R12 slice0 period", per, 4);
    endtask

    task automatic t_extremes;
        int bad_lo = 0;
        int bad_hi = 0;
        reg_wr(2, 2, 5); reg_wr(2, 3, 0);
        reg_wr(2, 4, 5); reg_wr(2, 5, 7);
        reg_wr(2, 0, 8'h04);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (pwm_out[4]) bad_lo++;
            if (!pwm_out[5]) bad_hi++;
        end
        check(bad_lo == 0, "R4 duty zero", bad_lo, 0);
        check(bad_hi == 0, "R5 duty above period", bad_hi, 0);
    endtask

    task automatic t_buffered;
        int hi, per;
        @(negedge clk);
        while (pwm_out[0]) @(negedge clk);
        while (!pwm_out[0]) @(negedge clk);
        wr_en = 1'b1; addr = {2'd0, 4'd3}; wdata = 8'd1;
        @(negedge clk);
        wr_en = 1'b0;
        check(pwm_out[0] == 1'b1, "R7 pulse keeps old duty", pwm_out[0], 1);
        @(negedge clk);
        check(pwm_out[0] == 1'b0, "R7 pulse ends on old duty", pwm_out[0], 0);
        measure(0, hi, per);
        check(hi == 1, "R7 new duty", hi, 1);
        check(per == 4, "R7 period kept", per, 4);
    endtask

    task automatic t_joined;
        int hi, per;
        reg_wr(3, 2, 8'h02); reg_wr(3, 4, 8'h01);
        reg_wr(3, 3, 8'h81); reg_wr(3, 5, 8'h00);
        reg_wr(3, 0, 8'h05);
        measure(6, hi, per);
        check(hi == 129, "R6 high", hi, 129);
        check(per == 259, "R6 period", per, 259);
        check(pwm_out[7] == 1'b0, "R6 upper pin low", pwm_out[7], 0);
    endtask

    task automatic t_lock;
        int hi, per;
        logic [7:0] v;
        reg_wr(3, 0, 8'h06);
        measure(6, hi, per);
        check(hi == 129, "R11 config locked high", hi, 129);
        check(per == 259, "R11 config locked period", per, 259);
        reg_wr(3, 0, 8'h00);
        repeat (3) @(negedge clk);
        check(pwm_out[6] == 1'b0, "R11 stop output", pwm_out[6], 0);
        reg_rd(3, 11, v);
        check(v == 0, "R11 stop count", v, 0);
    endtask

    task automatic t_capture;
        logic [7:0] c, v;
        reg_wr(3, 0, 8'h06);
        repeat (10) @(negedge clk);
        reg_rd(3, 11, c);
        pin_in[6] = 1'b1;
        repeat (4) @(negedge clk);
        check(pwm_out[7:6] == 2'b00, "R8 outputs low", pwm_out[7:6], 0);
        reg_rd(3, 6, v);  check(v == 8'(c + 8'd2), "R8 cap0 rise lo", v, 8'(c + 8'd2));
        reg_rd(3, 7, v);  check(v == 0, "R8 cap0 hi", v, 0);
        reg_rd(3, 10, v); check(v == 1, "R8 flag0", v, 1);
        check(irq[3] == 1'b1, "R10 irq set", irq[3], 1);
        reg_rd(3, 11, c);
        pin_in[7] = 1'b1;
        repeat (4) @(negedge clk);
        reg_rd(3, 8, v);  check(v == 8'(c + 8'd2), "R8 cap1 lo", v, 8'(c + 8'd2));
        reg_rd(3, 10, v); check(v == 3, "R8 flag1", v, 3);
        reg_rd(3, 11, c);
        pin_in[6] = 1'b0;
        repeat (4) @(negedge clk);
        reg_rd(3, 6, v);  check(v == 8'(c + 8'd2), "R8 cap0 fall lo", v, 8'(c + 8'd2));
        reg_wr(3, 10, 3);
        reg_rd(3, 10, v); check(v == 0, "R10 flags cleared", v, 0);
        check(irq[3] == 1'b0, "R10 irq clear", irq[3], 0);
    endtask

    task automatic t_overflow;
        logic [7:0] v;
        int n = 0;
        while (!irq[3] && n < 70000) begin @(negedge clk); n++; end
        check(irq[3] == 1'b1, "R9 irq on wrap", irq[3], 1);
        reg_rd(3, 10, v);
        check(v == 4, "R9 overflow flag", v, 4);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_split();
        t_prescale();
        t_extremes();
        t_buffered();
        t_joined();
        t_lock();
        t_capture();
        t_overflow();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule